// File: doc/BRIEF.md
# Frame ring pointer manager

This block keeps the bookkeeping for a circular buffer whose slots each hold one 32-byte frame. The ring length is a power of two. Four pointers describe the ring. The producer side has an allocated pointer, which marks slots reserved for writing, and a committed pointer, which marks slots holding finished data. The consumer side has a peeked pointer, which marks slots handed out for reading, and a discarded pointer, which marks slots released back to the producer. From these four pointers the block derives four occupancy counts and shows them continuously.

The block takes one command per clock cycle on a 3-bit opcode. A command can reserve a multiframe of 16 frames, commit one, peek one, discard one, flush the read side, or move a variable-length run of frames on either side. Each command is answered one cycle later with a grant flag, the granted frame count and the slot offset. The offset is a fixed base plus a pointer. It is also given as a multiframe number and as a 32-bit word address, ready for a DMA engine. The block holds no data; it does only the pointer arithmetic, so that several multiframes can be reserved or peeked before they are committed or discarded.

Top module: `frame_ring_ptr`

## Requirements
- R1: After reset all four pointers are zero, so the free count is the ring length minus 1, the allocated, valid and unseen counts are 0, and the grant output is low.
- R2: The counts are taken modulo the ring length: allocated = allocated ptr - discarded ptr; valid = committed ptr - discarded ptr; unseen = committed ptr - peeked ptr; free = discarded ptr - allocated ptr - 1.
- R3: Opcode 1 (reserve) is granted only when free >= 16. It then returns the allocated pointer, reports a length of 16 and advances the allocated pointer by 16.
- R4: Opcode 2 (commit) is always granted. It returns the committed pointer, reports a length of 16 and advances the committed pointer by 16, with no occupancy check.
- R5: Opcode 3 (peek) is granted only when unseen >= 16. It then returns the peeked pointer, reports a length of 16 and advances the peeked pointer by 16.
- R6: Opcode 4 (discard) is always granted. It returns the discarded pointer, reports a length of 16 and advances the discarded pointer by 16.
- R7: Opcode 5 (flush) is always granted with a length of 0. It sets both read pointers to the committed pointer with its low 4 bits cleared and returns that value.
- R8: Opcode 6 (bulk read) of req_len frames grants n = min(req_len, unseen, ring length - peeked ptr). When n > 0 it returns the peeked pointer and sets both read pointers to peeked + n.
- R9: Opcode 7 (bulk write) of req_len frames grants n = min(req_len, free, ring length - committed ptr). When n > 0 it returns the committed pointer and sets both write pointers to committed + n.
- R10: Opcode 0 (idle), a refused reserve or peek, and a bulk command with n = 0 change no pointer, and the next response has grant low, length 0 and offset 0.
- R11: The response offset is BASE + pointer. The multiframe number is offset >> 4 and the word address is offset << 3. All three are registered one cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_i | input | 3 | Command opcode (0 idle, 1 reserve, 2 commit, 3 peek, 4 discard, 5 flush, 6 bulk read, 7 bulk write) |
| req_len_i | input | PW+1 | Requested frame count for bulk commands |
| rsp_grant_o | output | 1 | Previous command was granted |
| rsp_len_o | output | PW+1 | Frames granted by previous command |
| rsp_ofs_o | output | OFS_W | Slot offset of granted command |
| rsp_mf_o | output | OFS_W-4 | Offset as multiframe number |
| rsp_word_o | output | OFS_W+3 | Offset as 32-bit word address |
| cnt_alloc_o | output | PW | Allocated frame count |
| cnt_valid_o | output | PW | Valid frame count |
| cnt_unseen_o | output | PW | Unseen frame count |
| cnt_free_o | output | PW | Free frame count |

## Verification
The bench fills the ring with reservations until one is refused at free = 15. A design that tested the gate with > instead of >= would lose the last multiframe, and one that did not test it at all would overrun the discard pointer. Bulk transfers are swept over many lengths, so that the clip at the ring wrap and the clip at the occupancy limit each become the binding limit. A design that ignored the wrap would return a run that crosses slot 0. A flush taken while the committed pointer is not aligned shows whether the low bits are cleared. A long pseudo-random command mix, which includes unchecked commits and discards, then compares every response and every count with an arithmetic model, where a single wrong mask or modulo shows up as a count mismatch.

// File: rtl/frr_pkg.sv
package frr_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_RESERVE = 3'd1,
    OP_COMMIT  = 3'd2,
    OP_PEEK    = 3'd3,
    OP_DISCARD = 3'd4,
    OP_FLUSH   = 3'd5,
    OP_BULK_RD = 3'd6,
    OP_BULK_WR = 3'd7
  } frr_op_e;

  // Pointer slots inside the pointer bank
  localparam int PI_WC   = 0;  // committed write
  localparam int PI_WA   = 1;  // allocated write
  localparam int PI_RD   = 2;  // discarded read
  localparam int PI_RP   = 3;  // peeked read
  localparam int NUM_PTR = 4;

endpackage

// File: rtl/frr_ptr_bank.sv
module frr_ptr_bank #(
  parameter int PW   = 7,
  parameter int NPTR = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPTR-1:0]          en_i,
  input  logic [NPTR-1:0][PW-1:0]  d_i,
  output logic [NPTR-1:0][PW-1:0]  q_o
);

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic [PW-1:0] ptr_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_r <= '0;
      else if (en_i[i]) ptr_r <= d_i[i];
    end
    assign q_o[i] = ptr_r;
  end

endmodule

// File: rtl/frr_occupancy.sv
module frr_occupancy #(
  parameter int PW = 7
) (
  input  logic [PW-1:0] wc_i,
  input  logic [PW-1:0] wa_i,
  input  logic [PW-1:0] rd_i,
  input  logic [PW-1:0] rp_i,
  output logic [PW-1:0] alloc_o,
  output logic [PW-1:0] valid_o,
  output logic [PW-1:0] unseen_o,
  output logic [PW-1:0] free_o
);

  localparam logic [PW-1:0] ONE = PW'(1);

  // PW-bit subtraction wraps modulo the ring length on its own
  always_comb begin
    alloc_o  = wa_i - rd_i;
    valid_o  = wc_i - rd_i;
    unseen_o = wc_i - rp_i;
    free_o   = rd_i - wa_i - ONE;
  end

endmodule

// File: rtl/frr_span_clip.sv
module frr_span_clip #(
  parameter int PW = 7
) (
  input  logic [PW:0]   req_i,
  input  logic [PW-1:0] avail_i,
  input  logic [PW-1:0] ptr_i,
  output logic [PW:0]   n_o
);

  localparam logic [PW:0] RING = (PW+1)'(1) << PW;

  logic [PW:0] room;
  logic [PW:0] avail_x;
  logic [PW:0] lim;

  always_comb begin
    room    = RING - {1'b0, ptr_i};
    avail_x = {1'b0, avail_i};
    lim     = (req_i < avail_x) ? req_i : avail_x;
    n_o     = (lim < room) ? lim : room;
  end

endmodule

// File: rtl/frame_ring_ptr.sv
module frame_ring_ptr
  import frr_pkg::*;
#(
  parameter int          PW      = 7,
  parameter int          MF_LOG2 = 4,
  parameter int          OFS_W   = 16,
  parameter int unsigned BASE    = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op_i,
  input  logic [PW:0]          req_len_i,
  output logic                 rsp_grant_o,
  output logic [PW:0]          rsp_len_o,
  output logic [OFS_W-1:0]     rsp_ofs_o,
  output logic [OFS_W-5:0]     rsp_mf_o,
  output logic [OFS_W+2:0]     rsp_word_o,
  output logic [PW-1:0]        cnt_alloc_o,
  output logic [PW-1:0]        cnt_valid_o,
  output logic [PW-1:0]        cnt_unseen_o,
  output logic [PW-1:0]        cnt_free_o
);

  localparam int              MF       = 1 << MF_LOG2;
  localparam logic [PW-1:0]   MF_P     = PW'(MF);
  localparam logic [PW:0]     MF_LEN   = (PW+1)'(MF);
  localparam logic [PW-1:0]   ALIGN_M  = ~(MF_P - PW'(1));
  localparam logic [OFS_W-1:0] BASE_O  = OFS_W'(BASE);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Pointer bank
  logic [NUM_PTR-1:0]         ptr_en;
  logic [NUM_PTR-1:0][PW-1:0] ptr_d;
  logic [NUM_PTR-1:0][PW-1:0] ptr_q;

  frr_ptr_bank #(.PW(PW), .NPTR(NUM_PTR)) u_bank (
    .clk  (clk),
    .rst_n(rst_q),
    .en_i (ptr_en),
    .d_i  (ptr_d),
    .q_o  (ptr_q)
  );

  logic [PW-1:0] wc, wa, rd, rp;
  assign wc = ptr_q[PI_WC];
  assign wa = ptr_q[PI_WA];
  assign rd = ptr_q[PI_RD];
  assign rp = ptr_q[PI_RP];

  // Occupancy
  logic [PW-1:0] c_alloc, c_valid, c_unseen, c_free;

  frr_occupancy #(.PW(PW)) u_occ (
    .wc_i    (wc),
    .wa_i    (wa),
    .rd_i    (rd),
    .rp_i    (rp),
    .alloc_o (c_alloc),
    .valid_o (c_valid),
    .unseen_o(c_unseen),
    .free_o  (c_free)
  );

  assign cnt_alloc_o  = c_alloc;
  assign cnt_valid_o  = c_valid;
  assign cnt_unseen_o = c_unseen;
  assign cnt_free_o   = c_free;

  // Run clipping for the two bulk directions
  logic [PW:0] n_rd, n_wr;

  frr_span_clip #(.PW(PW)) u_clip_rd (
    .req_i  (req_len_i),
    .avail_i(c_unseen),
    .ptr_i  (rp),
    .n_o    (n_rd)
  );

  frr_span_clip #(.PW(PW)) u_clip_wr (
    .req_i  (req_len_i),
    .avail_i(c_free),
    .ptr_i  (wc),
    .n_o    (n_wr)
  );

  // Next-state logic
  frr_op_e          op;
  logic             grant_d;
  logic [PW:0]      len_d;
  logic [PW-1:0]    sel_ptr;
  logic [PW-1:0]    flush_ptr;
  logic [PW-1:0]    rd_adv, wr_adv;

  assign op        = frr_op_e'(op_i);
  assign flush_ptr = wc & ALIGN_M;
  assign rd_adv    = rp + n_rd[PW-1:0];
  assign wr_adv    = wc + n_wr[PW-1:0];

  always_comb begin
    ptr_en  = '0;
    ptr_d   = ptr_q;
    grant_d = 1'b0;
    len_d   = '0;
    sel_ptr = '0;
    unique case (op)
      OP_RESERVE: begin
        if (c_free >= MF_P) begin
          grant_d       = 1'b1;
          len_d         = MF_LEN;
          sel_ptr       = wa;
          ptr_en[PI_WA] = 1'b1;
          ptr_d[PI_WA]  = wa + MF_P;
        end
      end
      OP_COMMIT: begin
        grant_d       = 1'b1;
        len_d         = MF_LEN;
        sel_ptr       = wc;
        ptr_en[PI_WC] = 1'b1;
        ptr_d[PI_WC]  = wc + MF_P;
      end
      OP_PEEK: begin
        if (c_unseen >= MF_P) begin
          grant_d       = 1'b1;
          len_d         = MF_LEN;
          sel_ptr       = rp;
          ptr_en[PI_RP] = 1'b1;
          ptr_d[PI_RP]  = rp + MF_P;
        end
      end
      OP_DISCARD: begin
        grant_d       = 1'b1;
        len_d         = MF_LEN;
        sel_ptr       = rd;
        ptr_en[PI_RD] = 1'b1;
        ptr_d[PI_RD]  = rd + MF_P;
      end
      OP_FLUSH: begin
        grant_d       = 1'b1;
        sel_ptr       = flush_ptr;
        ptr_en[PI_RD] = 1'b1;
        ptr_en[PI_RP] = 1'b1;
        ptr_d[PI_RD]  = flush_ptr;
        ptr_d[PI_RP]  = flush_ptr;
      end
      OP_BULK_RD: begin
        if (n_rd != '0) begin
          grant_d       = 1'b1;
          len_d         = n_rd;
          sel_ptr       = rp;
          ptr_en[PI_RD] = 1'b1;
          ptr_en[PI_RP] = 1'b1;
          ptr_d[PI_RD]  = rd_adv;
          ptr_d[PI_RP]  = rd_adv;
        end
      end
      OP_BULK_WR: begin
        if (n_wr != '0) begin
          grant_d       = 1'b1;
          len_d         = n_wr;
          sel_ptr       = wc;
          ptr_en[PI_WC] = 1'b1;
          ptr_en[PI_WA] = 1'b1;
          ptr_d[PI_WC]  = wr_adv;
          ptr_d[PI_WA]  = wr_adv;
        end
      end
      default: ;
    endcase
  end

  logic [OFS_W-1:0] ofs_d;
  assign ofs_d = grant_d ? (BASE_O + OFS_W'(sel_ptr)) : '0;

  // Response registers
  logic             grant_q;
  logic [PW:0]      len_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      grant_q <= 1'b0;
      len_q   <= '0;
      ofs_q   <= '0;
    end else begin
      grant_q <= grant_d;
      len_q   <= len_d;
      ofs_q   <= ofs_d;
    end
  end

  assign rsp_grant_o = grant_q;
  assign rsp_len_o   = len_q;
  assign rsp_ofs_o   = ofs_q;
  assign rsp_mf_o    = ofs_q[OFS_W-1:MF_LOG2];
  assign rsp_word_o  = {ofs_q, 3'b000};

  // Assertions
  assert_reserve_gate_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (op_i == OP_RESERVE && cnt_free_o < MF_P) |=> (!rsp_grant_o && $stable(cnt_alloc_o)));

  assert_peek_gate_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (op_i == OP_PEEK && cnt_unseen_o < MF_P) |=> (!rsp_grant_o && $stable(cnt_unseen_o)));

  assert_flush_align_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (op_i == OP_FLUSH) |=> (cnt_valid_o == cnt_unseen_o && cnt_valid_o < MF_P));

  assert_bulk_rd_limit_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (op_i == OP_BULK_RD) |=> (rsp_len_o <= {1'b0, $past(cnt_unseen_o)}));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (op_i == OP_IDLE) |=> (!rsp_grant_o && $stable(cnt_alloc_o) && $stable(cnt_valid_o)
                           && $stable(cnt_unseen_o) && $stable(cnt_free_o)));

endmodule

// File: tb/sim_frame_ring_ptr.sv
module sim_frame_ring_ptr;

  localparam int PW    = 7;
  localparam int OFS_W = 16;
  localparam int BASE  = 512;
  localparam int LEN   = 1 << PW;
  localparam int MASK  = LEN - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       op;
  logic [PW:0]      req;
  logic             grant;
  logic [PW:0]      len;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-5:0] mf;
  logic [OFS_W+2:0] word;
  logic [PW-1:0]    c_alloc, c_valid, c_unseen, c_free;

  always #5 clk = ~clk;

  frame_ring_ptr #(.PW(PW), .MF_LOG2(4), .OFS_W(OFS_W), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .req_len_i(req),
    .rsp_grant_o(grant), .rsp_len_o(len), .rsp_ofs_o(ofs), .rsp_mf_o(mf),
    .rsp_word_o(word), .cnt_alloc_o(c_alloc), .cnt_valid_o(c_valid),
    .cnt_unseen_o(c_unseen), .cnt_free_o(c_free)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Model pointers
  int m_wc, m_wa, m_rd, m_rp;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int f_free();   return (m_rd - m_wa - 1) & MASK; endfunction
  function automatic int f_unseen(); return (m_wc - m_rp) & MASK;     endfunction
  function automatic int f_valid();  return (m_wc - m_rd) & MASK;     endfunction
  function automatic int f_alloc();  return (m_wa - m_rd) & MASK;     endfunction
  function automatic int min3(input int a, input int b, input int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  task automatic check_counts(input string tag);
    check(int'(c_alloc)  == f_alloc(),  tag, "alloc count",  int'(c_alloc),  f_alloc());
    check(int'(c_valid)  == f_valid(),  tag, "valid count",  int'(c_valid),  f_valid());
    check(int'(c_unseen) == f_unseen(), tag, "unseen count", int'(c_unseen), f_unseen());
    check(int'(c_free)   == f_free(),   tag, "free count",   int'(c_free),   f_free());
  endtask

  // Issue one command at a falling edge, check after the next rising edge
  task automatic step(input int o, input int r);
    bit    eg = 1'b0;
    int    el = 0, ep = 0, n;
    string tag;
    int    pa = f_alloc(), pv = f_valid(), pu = f_unseen(), pf = f_free();
    case (o)
      1: begin tag = "R3"; if (f_free() >= 16) begin eg = 1; el = 16; ep = m_wa; m_wa = (m_wa + 16) & MASK; end end
      2: begin tag = "R4"; eg = 1; el = 16; ep = m_wc; m_wc = (m_wc + 16) & MASK; end
      3: begin tag = "R5"; if (f_unseen() >= 16) begin eg = 1; el = 16; ep = m_rp; m_rp = (m_rp + 16) & MASK; end end
      4: begin tag = "R6"; eg = 1; el = 16; ep = m_rd; m_rd = (m_rd + 16) & MASK; end
      5: begin tag = "R7"; eg = 1; el = 0; ep = m_wc & ~15; m_rd = ep; m_rp = ep; end
      6: begin
        tag = "R8";
        n = min3(r, f_unseen(), LEN - m_rp);
        if (n > 0) begin eg = 1; el = n; ep = m_rp; m_rp = (m_rp + n) & MASK; m_rd = m_rp; end
      end
      7: begin
        tag = "R9";
        n = min3(r, f_free(), LEN - m_wc);
        if (n > 0) begin eg = 1; el = n; ep = m_wc; m_wc = (m_wc + n) & MASK; m_wa = m_wc; end
      end
      default: tag = "R10";
    endcase
    op  = 3'(o);
    req = (PW+1)'(r);
    @(posedge clk);
    @(negedge clk);
    op  = 3'd0;
    req = '0;
    check(grant == eg, tag, "grant", int'(grant), int'(eg));
    check(int'(len) == el, tag, "length", int'(len), el);
    begin
      int eo = eg ? (BASE + ep) : 0;
      check(int'(ofs) == eo, tag, "offset", int'(ofs), eo);
      check(int'(mf) == (eo >> 4), "R11", "multiframe number", int'(mf), eo >> 4);
      check(int'(word) == (eo << 3), "R11", "word address", int'(word), eo << 3);
    end
    check_counts("R2");
    if (!eg) begin
      check(int'(c_alloc) == pa && int'(c_valid) == pv && int'(c_unseen) == pu
            && int'(c_free) == pf, "R10", "counts unchanged after refused/idle",
            int'(c_free), pf);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op    = 3'd0;
    req   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_wc = 0; m_wa = 0; m_rd = 0; m_rp = 0;
    check(grant == 1'b0, "R1", "grant after reset", int'(grant), 0);
    check(int'(c_free) == LEN - 1, "R1", "free after reset", int'(c_free), LEN - 1);
    check(c_alloc == '0 && c_valid == '0 && c_unseen == '0, "R1", "other counts after reset",
          int'(c_alloc) + int'(c_valid) + int'(c_unseen), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst_n = 1'b0;
    op    = 3'd0;
    req   = '0;
    do_reset();

    // R3: fill until refused at free = 15
    for (int i = 0; i < 8; i++) step(1, 0);
    // R4: commit the reservations
    for (int i = 0; i < 7; i++) step(2, 0);
    // R5: peek until refused
    for (int i = 0; i < 8; i++) step(3, 0);
    // R6: release
    for (int i = 0; i < 7; i++) step(4, 0);
    // R10: idle cycles
    for (int i = 0; i < 3; i++) step(0, 0);

    // R8 / R9: bulk length sweep crossing the wrap many times
    for (int l = 0; l <= LEN; l++) begin
      step(7, l);
      step(6, (l * 3) % (LEN + 1));
    end
    // R7: flush on an unaligned committed pointer
    step(7, 5);
    step(7, 22);
    step(5, 0);
    step(6, 200 % (LEN + 1));
    step(5, 0);

    // Mixed pseudo-random commands
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[2:0]), int'({lfsr[12], lfsr[10:4]}));
    end

    // R1: reset in the middle of traffic
    do_reset();
    step(6, 10);
    step(3, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule